// File: doc/BRIEF.md
# Two-Page Dual-Port Scratch RAM

This block is an on-chip scratch RAM of two pages, served by two request ports that can run at the same time. The fast port answers in the same cycle it is asked, provided its page is free. The system port follows a valid/ready handshake and always answers after a fixed latency. Each port decodes a 29-bit byte address. Only two 64-kbyte windows are accepted, and the window picks the page. Any other address gets an error response.

When the two ports work on different pages, both run at full speed. A system-port access claims its page from the cycle after it is accepted through its ready cycle. A fast-port request to a claimed page waits until the page is released. If both ports ask for the same idle page in the same cycle, the fast request goes first and the system request is accepted one cycle later.

The storage depth per page is a parameter. The default keeps 256 words per page, and the unused upper offset bits alias onto those words.

Top module: `dps_ram`

## Requirements
- R1: Addresses 0x055F0000..0x055FFFFF select page 0 and 0x05600000..0x0560FFFF select page 1. The word within a page is addr[WORD_BITS+1:2], and higher offset bits alias (default WORD_BITS=8).
- R2: A fast-port request in range to a page the system port does not hold gets f_ready in the same cycle. A write lands at that clock edge, and read data is on f_rdata in that cycle.
- R3: A system-port request accepted in cycle c raises s_ready for exactly one cycle, in cycle c+SYS_LAT (default 2). The initiator holds s_valid and the request fields until then.
- R4: Byte enable bit i writes data bits 8i+7:8i and leaves the other lanes unchanged. be[3] with bits 31:24 is the lowest byte address (big-endian). The same rule holds on both ports.
- R5: From the cycle after a system access is accepted through its s_ready cycle, a fast request to the same page sees f_ready low. It completes in the first cycle after s_ready.
- R6: When both ports request the same idle page in the same cycle, the fast access completes in that cycle. The system request is accepted in the next cycle, so its s_ready comes one cycle later than it would otherwise.
- R7: Accesses to different pages overlap with no added wait. A fast access completes in the same cycle as a system access to the other page, including the system port's ready cycle.
- R8: An address outside both windows writes nothing and claims no page. On the fast port it gets f_ready and f_err in the same cycle. On the system port it gets s_ready and s_err after the normal latency. Read data is zero in both cases.
- R9: After reset, with no request present, f_ready, f_err, s_ready and s_err are low.
- R10: Both ports reach the same storage. A word written through one port reads back through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| f_req | input | 1 | Fast-port request |
| f_we | input | 1 | Fast-port write (1) or read (0) |
| f_be | input | 4 | Fast-port byte enables |
| f_addr | input | 29 | Fast-port byte address |
| f_wdata | input | 32 | Fast-port write data |
| f_ready | output | 1 | Fast-port access completes this cycle |
| f_err | output | 1 | Fast-port address out of range |
| f_rdata | output | 32 | Fast-port read data |
| s_valid | input | 1 | System-port request valid |
| s_we | input | 1 | System-port write (1) or read (0) |
| s_be | input | 4 | System-port byte enables |
| s_addr | input | 29 | System-port byte address |
| s_wdata | input | 32 | System-port write data |
| s_ready | output | 1 | System-port access completes this cycle |
| s_err | output | 1 | System-port address out of range |
| s_rdata | output | 32 | System-port read data |

## Verification
The checker assumes that the system-port initiator keeps s_valid and its request fields steady from acceptance until s_ready, and drops or changes the request only after that cycle. It also assumes that a fast requester holds f_req and its fields while f_ready is low. The bench drives both ports at the falling edge and moves on only after it has seen the matching ready, so every stimulus stays inside these assumptions. The overlap, collision and tie cases are driven cycle by cycle so the bench can predict each port's ready cycle exactly.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int ADDR_W   = 29;
  localparam int DATA_W   = 32;
  localparam int BE_W     = DATA_W / 8;
  localparam int NUM_PAGES = 2;
  localparam int TAG_LSB  = 16;
  localparam int TAG_W    = ADDR_W - TAG_LSB;

  localparam logic [TAG_W-1:0] TAG_PAGE0 = 13'h055F;
  localparam logic [TAG_W-1:0] TAG_PAGE1 = 13'h0560;

  // address falls inside one of the two windows
  function automatic logic win_hit(input logic [ADDR_W-1:0] a);
    return (a[ADDR_W-1:TAG_LSB] == TAG_PAGE0) || (a[ADDR_W-1:TAG_LSB] == TAG_PAGE1);
  endfunction

  // page number of an in-range address
  function automatic logic win_page(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:TAG_LSB] == TAG_PAGE1;
  endfunction

  // merge new lanes into an old word under byte enables
  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_w,
                                                  input logic [DATA_W-1:0] new_w,
                                                  input logic [BE_W-1:0]   be);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int i = 0; i < BE_W; i++)
      if (be[i]) r[8*i +: 8] = new_w[8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/dps_decode.sv
module dps_decode
  import dps_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 hit,
  output logic                 page,
  output logic [WORD_BITS-1:0] idx
);
  assign hit  = win_hit(addr);
  assign page = win_page(addr);
  assign idx  = addr[WORD_BITS+1:2];
endmodule

// File: rtl/dps_sys_seq.sv
module dps_sys_seq
  import dps_pkg::*;
#(
  parameter int SYS_LAT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid,
  input  logic                 hit,
  input  logic                 page,
  input  logic [NUM_PAGES-1:0] fast_on,
  output logic                 busy,
  output logic                 held_page,
  output logic                 held_bad,
  output logic                 accept,
  output logic                 ready
);
  localparam int CNT_W = $clog2(SYS_LAT + 1);

  logic [CNT_W-1:0] cnt;

  // a fresh request waits while the fast port uses its page this cycle
  assign accept = valid && !busy && (!hit || !fast_on[page]);
  assign ready  = busy && (cnt == CNT_W'(SYS_LAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      held_page <= 1'b0;
      held_bad  <= 1'b0;
    end else if (accept) begin
      busy      <= 1'b1;
      cnt       <= CNT_W'(1);
      held_page <= page;
      held_bad  <= !hit;
    end else if (ready) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dps_bank.sv
module dps_bank
  import dps_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [BE_W-1:0]      be,
  input  logic [WORD_BITS-1:0] idx,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata
);
  localparam int WORDS = 1 << WORD_BITS;

  logic [DATA_W-1:0] mem [WORDS];

  assign rdata = mem[idx];

  for (genvar ln = 0; ln < BE_W; ln++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && be[ln]) mem[idx][8*ln +: 8] <= wdata[8*ln +: 8];
    end
  end
endmodule

// File: rtl/dps_ram.sv
module dps_ram
  import dps_pkg::*;
#(
  parameter int WORD_BITS = 8,
  parameter int SYS_LAT   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        f_req,
  input  logic        f_we,
  input  logic [3:0]  f_be,
  input  logic [28:0] f_addr,
  input  logic [31:0] f_wdata,
  output logic        f_ready,
  output logic        f_err,
  output logic [31:0] f_rdata,
  input  logic        s_valid,
  input  logic        s_we,
  input  logic [3:0]  s_be,
  input  logic [28:0] s_addr,
  input  logic [31:0] s_wdata,
  output logic        s_ready,
  output logic        s_err,
  output logic [31:0] s_rdata
);
  logic                 f_hit, f_page, s_hit, s_page;
  logic [WORD_BITS-1:0] f_idx, s_idx;
  logic                 s_busy, s_held_page, s_held_bad, s_accept;
  logic                 f_conflict, f_go;
  logic [NUM_PAGES-1:0] f_on, s_final_on;
  logic [DATA_W-1:0]    bank_rd [NUM_PAGES];

  dps_decode #(.WORD_BITS(WORD_BITS)) u_fdec (
    .addr(f_addr), .hit(f_hit), .page(f_page), .idx(f_idx));
  dps_decode #(.WORD_BITS(WORD_BITS)) u_sdec (
    .addr(s_addr), .hit(s_hit), .page(s_page), .idx(s_idx));

  // fast side: blocked only by a held, in-range page of the system port
  assign f_conflict = f_req && f_hit && s_busy && !s_held_bad && (s_held_page == f_page);
  assign f_go       = f_req && f_hit && !f_conflict;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    logic          b_we;
    logic [BE_W-1:0] b_be;
    logic [WORD_BITS-1:0] b_idx;
    logic [DATA_W-1:0]    b_wd;

    assign f_on[p]       = f_go && (f_page == 1'(p));
    assign s_final_on[p] = s_ready && !s_held_bad && (s_held_page == 1'(p));

    always_comb begin
      if (s_busy && !s_held_bad && (s_held_page == 1'(p))) begin
        b_we  = s_final_on[p] && s_we;
        b_be  = s_be;
        b_idx = s_idx;
        b_wd  = s_wdata;
      end else begin
        b_we  = f_on[p] && f_we;
        b_be  = f_be;
        b_idx = f_idx;
        b_wd  = f_wdata;
      end
    end

    dps_bank #(.WORD_BITS(WORD_BITS)) u_bank (
      .clk(clk), .we(b_we), .be(b_be), .idx(b_idx), .wdata(b_wd), .rdata(bank_rd[p]));
  end

  dps_sys_seq #(.SYS_LAT(SYS_LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .valid(s_valid), .hit(s_hit), .page(s_page),
    .fast_on(f_on), .busy(s_busy), .held_page(s_held_page), .held_bad(s_held_bad),
    .accept(s_accept), .ready(s_ready));

  assign f_ready = f_go || (f_req && !f_hit);
  assign f_err   = f_req && !f_hit;
  assign f_rdata = (f_go && !f_we) ? bank_rd[f_page] : '0;

  assign s_err   = s_ready && s_held_bad;
  assign s_rdata = (s_ready && !s_held_bad && !s_we) ? bank_rd[s_held_page] : '0;
endmodule

// File: rtl/dps_ram_chk.sv
module dps_ram_chk (
  input logic clk,
  input logic rst_n,
  input logic f_req,
  input logic f_ready,
  input logic f_err,
  input logic s_valid,
  input logic s_ready,
  input logic s_err,
  input logic f_conflict,
  input logic s_accept,
  input logic s_busy
);
  // R2
  f_prompt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_req && !f_conflict) |-> f_ready);
  // R5
  f_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_conflict |-> (!f_ready && s_busy));
  // R3
  s_not_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_accept |=> !s_ready);
  // R3
  s_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);
  // R3
  s_valid_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> s_valid);
  // R8
  f_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_err |-> f_ready);
  // R8
  s_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_err |-> s_ready);
  // R9
  f_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !f_req |-> !f_ready);
endmodule

bind dps_ram dps_ram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .f_req(f_req), .f_ready(f_ready), .f_err(f_err),
  .s_valid(s_valid), .s_ready(s_ready), .s_err(s_err),
  .f_conflict(f_conflict), .s_accept(s_accept), .s_busy(s_busy));

// File: tb/dps_ram_test.sv
module dps_ram_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        f_req = 1'b0, f_we = 1'b0;
  logic [3:0]  f_be = 4'h0;
  logic [28:0] f_addr = '0;
  logic [31:0] f_wdata = '0;
  logic        f_ready, f_err;
  logic [31:0] f_rdata;
  logic        s_valid = 1'b0, s_we = 1'b0;
  logic [3:0]  s_be = 4'h0;
  logic [28:0] s_addr = '0;
  logic [31:0] s_wdata = '0;
  logic        s_ready, s_err;
  logic [31:0] s_rdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dps_ram uut (.*);

  // {we, be, addr, wdata, exp_rdata, exp_err}
  localparam int NV = 13;
  localparam logic [98:0] VEC [NV] = '{
    {1'b1, 4'hF, 29'h055F0000, 32'h11223344, 32'h0, 1'b0},   // R2
    {1'b1, 4'hF, 29'h05600004, 32'hAABBCCDD, 32'h0, 1'b0},   // R1
    {1'b0, 4'hF, 29'h055F0000, 32'h0, 32'h11223344, 1'b0},   // R2
    {1'b0, 4'hF, 29'h05600004, 32'h0, 32'hAABBCCDD, 1'b0},   // R1
    {1'b1, 4'h8, 29'h055F0000, 32'hEE000000, 32'h0, 1'b0},   // R4
    {1'b0, 4'hF, 29'h055F0000, 32'h0, 32'hEE223344, 1'b0},   // R4
    {1'b1, 4'h1, 29'h05600004, 32'h00000099, 32'h0, 1'b0},   // R4
    {1'b0, 4'hF, 29'h05600004, 32'h0, 32'hAABBCC99, 1'b0},   // R4
    {1'b1, 4'hF, 29'h05610004, 32'hFFFFFFFF, 32'h0, 1'b1},   // R8
    {1'b0, 4'hF, 29'h05600004, 32'h0, 32'hAABBCC99, 1'b0},   // R8 unchanged
    {1'b0, 4'hF, 29'h055EFFFC, 32'h0, 32'h0, 1'b1},          // R8
    {1'b1, 4'hF, 29'h055F0400, 32'h0BADF00D, 32'h0, 1'b0},   // R1 alias
    {1'b0, 4'hF, 29'h055F0000, 32'h0, 32'h0BADF00D, 1'b0}    // R1 alias
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fast_set(input logic we, input logic [3:0] be, input logic [28:0] a,
                          input logic [31:0] d);
    f_req = 1'b1; f_we = we; f_be = be; f_addr = a; f_wdata = d;
  endtask

  task automatic sys_set(input logic we, input logic [3:0] be, input logic [28:0] a,
                         input logic [31:0] d);
    s_valid = 1'b1; s_we = we; s_be = be; s_addr = a; s_wdata = d;
  endtask

  // system access alone; returns cycles from accept to ready
  task automatic sys_run(input logic we, input logic [28:0] a, input logic [31:0] d,
                         output int lat, output logic [31:0] rd, output logic er);
    @(negedge clk);
    sys_set(we, 4'hF, a, d);
    lat = 0;
    forever begin
      #4;
      if (s_ready) begin rd = s_rdata; er = s_err; break; end
      lat++;
      if (lat > 20) begin rd = 'x; er = 'x; break; end
      @(negedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic [31:0] rd;
    logic er;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #4;
    // R9 reset state
    chk("R9 f_ready", 32'(f_ready), 32'h0);
    chk("R9 s_ready", 32'(s_ready), 32'h0);
    chk("R9 errs", 32'({f_err, s_err}), 32'h0);

    // table walk on the fast port
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fast_set(VEC[i][98], VEC[i][97:94], VEC[i][93:65], VEC[i][64:33]);
      #4;
      chk($sformatf("R2 vec%0d ready", i), 32'(f_ready), 32'h1);
      chk($sformatf("R8 vec%0d err", i), 32'(f_err), 32'(VEC[i][0]));
      chk($sformatf("R4 vec%0d rdata", i), f_rdata, VEC[i][32:1]);
      @(negedge clk);
      f_req = 1'b0;
    end

    // R3 latency, R10 shared storage
    sys_run(1'b1, 29'h05600008, 32'hCAFE0001, lat, rd, er);
    chk("R3 sys write latency", 32'(lat), 32'd2);
    chk("R3 sys write err", 32'(er), 32'h0);
    @(negedge clk); fast_set(1'b0, 4'hF, 29'h05600008, '0); #4;
    chk("R10 fast sees sys write", f_rdata, 32'hCAFE0001);
    @(negedge clk); f_req = 1'b0;
    sys_run(1'b0, 29'h055F0000, '0, lat, rd, er);
    chk("R10 sys sees fast write", rd, 32'h0BADF00D);
    chk("R3 sys read latency", 32'(lat), 32'd2);

    // R8 system-port error
    sys_run(1'b0, 29'h04000000, '0, lat, rd, er);
    chk("R8 sys err", 32'(er), 32'h1);
    chk("R8 sys err latency", 32'(lat), 32'd2);
    chk("R8 sys err rdata", rd, 32'h0);

    // R5 collision: system holds page 0, fast waits
    @(negedge clk); sys_set(1'b1, 4'hF, 29'h055F0010, 32'h00000005);
    @(negedge clk); fast_set(1'b0, 4'hF, 29'h055F0000, '0); #4;
    chk("R5 stall c1", 32'(f_ready), 32'h0);
    @(negedge clk); #4;
    chk("R5 stall c2", 32'(f_ready), 32'h0);
    chk("R5 sys ready c2", 32'(s_ready), 32'h1);
    @(negedge clk); s_valid = 1'b0; #4;
    chk("R5 fast resumes", 32'(f_ready), 32'h1);
    chk("R5 fast data", f_rdata, 32'h0BADF00D);
    @(negedge clk); f_req = 1'b0;

    // R6 tie on idle page 1
    @(negedge clk);
    sys_set(1'b1, 4'hF, 29'h0560000C, 32'h600D600D);
    fast_set(1'b0, 4'hF, 29'h05600004, '0); #4;
    chk("R6 fast first", 32'(f_ready), 32'h1);
    chk("R6 fast data", f_rdata, 32'hAABBCC99);
    @(negedge clk); f_req = 1'b0; #4;
    chk("R6 sys c1", 32'(s_ready), 32'h0);
    @(negedge clk); #4;
    chk("R6 sys c2", 32'(s_ready), 32'h0);
    @(negedge clk); #4;
    chk("R6 sys c3", 32'(s_ready), 32'h1);
    @(negedge clk); s_valid = 1'b0;

    // R7 overlap on different pages
    @(negedge clk); sys_set(1'b0, 4'hF, 29'h055F0010, '0);
    @(negedge clk); fast_set(1'b1, 4'hF, 29'h05600010, 32'h00000077); #4;
    chk("R7 fast write no wait", 32'(f_ready), 32'h1);
    @(negedge clk); fast_set(1'b0, 4'hF, 29'h05600010, '0); #4;
    chk("R7 fast read no wait", 32'(f_ready), 32'h1);
    chk("R7 fast data", f_rdata, 32'h00000077);
    chk("R7 sys ready same cycle", 32'(s_ready), 32'h1);
    chk("R7 sys data", s_rdata, 32'h00000005);
    @(negedge clk); f_req = 1'b0; s_valid = 1'b0;

    // R8 out-of-range fast access is not stalled by a held page
    @(negedge clk); sys_set(1'b0, 4'hF, 29'h055F0010, '0);
    @(negedge clk); fast_set(1'b1, 4'hF, 29'h07000000, 32'h1); #4;
    chk("R8 fast err not stalled", 32'({f_ready, f_err}), 32'h3);
    @(negedge clk); f_req = 1'b0;
    @(negedge clk); s_valid = 1'b0;

    // R4 byte write on system port
    @(negedge clk); sys_set(1'b1, 4'h6, 29'h05600008, 32'h00ABCD00);
    repeat (3) @(negedge clk);
    s_valid = 1'b0;
    @(negedge clk); fast_set(1'b0, 4'hF, 29'h05600008, '0); #4;
    chk("R4 sys middle lanes", f_rdata, 32'hCAABCD01);
    @(negedge clk); f_req = 1'b0;

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule